// File: doc/BRIEF.md
# Multi-function DIO pin router

This block decides, every cycle, what each of four bidirectional digital lines is used for. A 16-bit function register can place up to three special functions on the lines: a data-ready output, an alarm output and an external sample-clock input. Each function has its own enable bit, polarity bit and 2-bit line selector. A line that no enabled function claims is handed to general-purpose I/O, which is controlled by a 16-bit GPIO register with a direction bit and a level bit for each line.

The block takes the two register values, an internal sample-clock event, an alarm flag and the synchronized pad inputs. It drives the pad output enables and output values, and it produces one sample strobe. That strobe comes from the internal clock, or from the selected edge of the chosen external line once the sync input is enabled. It also returns the GPIO readback levels. Each sample strobe starts a data-ready pulse of fixed length, driven at the programmed polarity. The register file and the serial host interface sit outside this block.

Top module: `dio_router`

## Requirements
- R1: Right after reset, with the function register at 0x000D and the GPIO register at zero, line 2 is the only line with its output enable set and it drives 0. While no external sync input is active, sample_strobe follows int_sample in the same cycle.
- R2: Each line selector (alarm bits [9:8], sync bits [5:4], data-ready bits [1:0]) maps 00, 01, 10 and 11 to lines 1, 2, 3 and 4 (pad bit 0 to bit 3). An enabled data-ready or alarm function sets the output enable of its line.
- R3: A sample strobe that is high at a clock edge makes the data-ready line active for exactly DRDY_LEN (4) cycles, starting right after that edge. The active level is 1 when bit 2 is 1 and 0 when bit 2 is 0. The line sits at the opposite level when idle.
- R4: The alarm line (enable bit 11) drives alarm_flag when bit 10 is 1 and its inverse when bit 10 is 0.
- R5: With the sync input enabled (bit 7), int_sample is ignored. sample_strobe pulses for one cycle on the selected edge of the chosen pad: rising when bit 6 is 1, falling when bit 6 is 0. The pulse appears after the second clock edge following the pad change, and the opposite edge gives no pulse.
- R6: The line claimed by the sync input has its output enable cleared.
- R7: On an unclaimed line, the output enable equals GPIO bit [i] (1 = output) and the output value equals GPIO bit [4+i].
- R8: gpio_levels bit i returns GPIO bit [4+i] for an unclaimed output line. For any other line it returns the pad level through a two-flop synchronizer, so a pad change shows after the second clock edge.
- R9: When enabled functions select the same line, data-ready wins over alarm and alarm wins over sync. A losing function is ignored, and a losing sync input leaves int_sample as the strobe source.
- R10: A function whose enable bit is 0 claims no line, whatever its selector and polarity bits hold.
- R11: Function register bits [15:12] and GPIO register bits [15:8] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| func_ctrl | input | 16 | Function routing register value |
| gpio_ctrl | input | 16 | GPIO direction [3:0] and level [7:4] register value |
| int_sample | input | 1 | One-cycle internal sample-clock event |
| alarm_flag | input | 1 | Internal alarm condition |
| pad_in | input | 4 | Levels sensed on the four lines |
| pad_oe | output | 4 | Output enable of each line |
| pad_out | output | 4 | Value driven on each line |
| sample_strobe | output | 1 | Selected sampling event, one cycle per sample |
| gpio_levels | output | 4 | GPIO readback levels |

## Verification
Ownership is decoded combinationally, so a wrong claim shows up on pad_oe and pad_out in the same cycle the register changes. Tests therefore drive every selector value, collisions between functions and disabled functions, then read the pads straight away. Faults in the synchronizer or in edge selection show only on sample_strobe. They appear as a pulse one cycle early or late, on the wrong edge, or as an internal event that leaks through in external mode, so those checks sample cycle by cycle around each pad change. A data-ready counter that loads or counts down wrongly makes the pulse one or more cycles longer or shorter, which the bench catches by counting the active cycles.

// File: rtl/dio_router_pkg.sv
package dio_router_pkg;

    localparam int NUM_LINES = 4;
    localparam int SEL_W     = $clog2(NUM_LINES);
    localparam int FN_BITS   = 3 * (SEL_W + 2);

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic [1:0] {
        OWN_GPIO  = 2'd0,
        OWN_DRDY  = 2'd1,
        OWN_ALARM = 2'd2,
        OWN_SYNC  = 2'd3
    } owner_e;

    // One routed function: enable, polarity/edge, line selector.
    typedef struct packed {
        logic             en;
        logic             pol;
        logic [SEL_W-1:0] sel;
    } fn_cfg_t;

    // Field order matches the register bit positions (alarm high, ready low).
    typedef struct packed {
        fn_cfg_t alarm;
        fn_cfg_t sync;
        fn_cfg_t drdy;
    } fn_ctrl_t;

    typedef struct packed {
        line_vec_t level;
        line_vec_t dir;
    } gpio_cfg_t;

    function automatic line_vec_t sel_to_mask(input logic [SEL_W-1:0] sel);
        return line_vec_t'(1) << sel;
    endfunction

    function automatic fn_ctrl_t unpack_fn(input logic [15:0] raw);
        return fn_ctrl_t'(raw[FN_BITS-1:0]);
    endfunction

endpackage

// File: rtl/dio_claim_decode.sv
module dio_claim_decode
    import dio_router_pkg::*;
(
    input  fn_ctrl_t  cfg,
    output line_vec_t drdy_mask,
    output line_vec_t alarm_mask,
    output line_vec_t sync_mask,
    output logic      ext_mode,
    output owner_e    owner [NUM_LINES]
);

    line_vec_t alarm_req;
    line_vec_t sync_req;

    always_comb begin
        drdy_mask = sel_to_mask(cfg.drdy.sel) & {NUM_LINES{cfg.drdy.en}};
        alarm_req = sel_to_mask(cfg.alarm.sel) & {NUM_LINES{cfg.alarm.en}};
        sync_req  = sel_to_mask(cfg.sync.sel) & {NUM_LINES{cfg.sync.en}};

        // Lower-priority functions lose a line already taken.
        alarm_mask = ((alarm_req & drdy_mask) == '0) ? alarm_req : '0;
        sync_mask  = ((sync_req & (drdy_mask | alarm_mask)) == '0) ? sync_req : '0;
        ext_mode   = |sync_mask;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_owner
        always_comb begin
            if (drdy_mask[i])       owner[i] = OWN_DRDY;
            else if (alarm_mask[i]) owner[i] = OWN_ALARM;
            else if (sync_mask[i])  owner[i] = OWN_SYNC;
            else                    owner[i] = OWN_GPIO;
        end
    end

endmodule

// File: rtl/dio_sync_sampler.sv
module dio_sync_sampler
    import dio_router_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  line_vec_t        pad_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             rising,
    input  logic             ext_mode,
    input  logic             int_sample,
    output line_vec_t        sync_q,
    output logic             strobe
);

    line_vec_t chain_q [STAGES];
    line_vec_t prev_q;
    line_vec_t rise_v;
    line_vec_t fall_v;
    logic      edge_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
            prev_q <= '0;
        end else begin
            chain_q[0] <= pad_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            prev_q <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        sync_q   = chain_q[STAGES-1];
        rise_v   = sync_q & ~prev_q;
        fall_v   = ~sync_q & prev_q;
        edge_hit = rising ? rise_v[sel] : fall_v[sel];
        strobe   = ext_mode ? edge_hit : int_sample;
    end

endmodule

// File: rtl/dio_ready_pulse.sv
module dio_ready_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);

    localparam int CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (trig)          cnt_q <= CNT_W'(LEN);
        else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/dio_router.sv
module dio_router
    import dio_router_pkg::*;
#(
    parameter int DRDY_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] func_ctrl,
    input  logic [15:0] gpio_ctrl,
    input  logic        int_sample,
    input  logic        alarm_flag,
    input  logic [3:0]  pad_in,
    output logic [3:0]  pad_oe,
    output logic [3:0]  pad_out,
    output logic        sample_strobe,
    output logic [3:0]  gpio_levels
);

    fn_ctrl_t  fn_cfg;
    gpio_cfg_t gp_cfg;
    line_vec_t drdy_mask;
    line_vec_t alarm_mask;
    line_vec_t sync_mask;
    logic      ext_mode;
    owner_e    owner [NUM_LINES];
    line_vec_t sync_q;
    logic      drdy_active;
    logic      drdy_level;
    logic      alarm_level;
    logic      unused_bits;

    assign fn_cfg      = unpack_fn(func_ctrl);
    assign gp_cfg      = gpio_cfg_t'(gpio_ctrl[2*NUM_LINES-1:0]);
    assign unused_bits = ^{func_ctrl[15:FN_BITS], gpio_ctrl[15:2*NUM_LINES]};

    dio_claim_decode u_decode (
        .cfg        (fn_cfg),
        .drdy_mask  (drdy_mask),
        .alarm_mask (alarm_mask),
        .sync_mask  (sync_mask),
        .ext_mode   (ext_mode),
        .owner      (owner)
    );

    dio_sync_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .pad_in     (pad_in),
        .sel        (fn_cfg.sync.sel),
        .rising     (fn_cfg.sync.pol),
        .ext_mode   (ext_mode),
        .int_sample (int_sample),
        .sync_q     (sync_q),
        .strobe     (sample_strobe)
    );

    dio_ready_pulse #(.LEN(DRDY_LEN)) u_ready (
        .clk    (clk),
        .rst    (rst),
        .trig   (sample_strobe),
        .active (drdy_active)
    );

    assign drdy_level  = fn_cfg.drdy.pol  ? drdy_active : ~drdy_active;
    assign alarm_level = fn_cfg.alarm.pol ? alarm_flag  : ~alarm_flag;

    always_comb begin
        pad_oe      = '0;
        pad_out     = '0;
        gpio_levels = sync_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            case (owner[i])
                OWN_DRDY: begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = drdy_level;
                end
                OWN_ALARM: begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = alarm_level;
                end
                OWN_SYNC: begin
                    pad_oe[i]  = 1'b0;
                end
                default: begin
                    pad_oe[i] = gp_cfg.dir[i];
                    if (gp_cfg.dir[i]) begin
                        pad_out[i]     = gp_cfg.level[i];
                        gpio_levels[i] = gp_cfg.level[i];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dio_router_chk.sv
module dio_router_chk
    import dio_router_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input line_vec_t gpio_dir,
    input line_vec_t drdy_mask,
    input line_vec_t alarm_mask,
    input line_vec_t sync_mask,
    input logic      ext_mode,
    input line_vec_t sync_q,
    input logic      sample_strobe,
    input logic      drdy_active,
    input line_vec_t pad_oe
);

    assert_one_line_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drdy_mask) && $onehot0(alarm_mask) && $onehot0(sync_mask));

    assert_no_shared_line_R9: assert property (@(posedge clk) disable iff (rst)
        ((drdy_mask & alarm_mask) == '0) && (((drdy_mask | alarm_mask) & sync_mask) == '0));

    assert_sync_line_input_R6: assert property (@(posedge clk) disable iff (rst)
        (sync_mask & pad_oe) == '0);

    assert_gpio_direction_R7: assert property (@(posedge clk) disable iff (rst)
        ((~(drdy_mask | alarm_mask | sync_mask)) & (pad_oe ^ gpio_dir)) == '0);

    assert_ext_needs_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && sample_strobe) |-> (sync_q != $past(sync_q)));

    assert_ready_follows_R3: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> drdy_active);

endmodule

bind dio_router dio_router_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .gpio_dir      (gp_cfg.dir),
    .drdy_mask     (drdy_mask),
    .alarm_mask    (alarm_mask),
    .sync_mask     (sync_mask),
    .ext_mode      (ext_mode),
    .sync_q        (sync_q),
    .sample_strobe (sample_strobe),
    .drdy_active   (drdy_active),
    .pad_oe        (pad_oe)
);

// File: tb/dio_router_test.sv
`timescale 1ns/1ps
module dio_router_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] func_ctrl;
    logic [15:0] gpio_ctrl;
    logic        int_sample;
    logic        alarm_flag;
    logic [3:0]  pad_in;
    logic [3:0]  pad_oe;
    logic [3:0]  pad_out;
    logic        sample_strobe;
    logic [3:0]  gpio_levels;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    dio_router uut (
        .clk           (clk),
        .rst           (rst),
        .func_ctrl     (func_ctrl),
        .gpio_ctrl     (gpio_ctrl),
        .int_sample    (int_sample),
        .alarm_flag    (alarm_flag),
        .pad_in        (pad_in),
        .pad_oe        (pad_oe),
        .pad_out       (pad_out),
        .sample_strobe (sample_strobe),
        .gpio_levels   (gpio_levels)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        int_sample = 1'b0;
        repeat (6) step();
    endtask

    task automatic t_reset();
        rst = 1'b1; func_ctrl = 16'h000D; gpio_ctrl = 16'h0000;
        int_sample = 1'b0; alarm_flag = 1'b0; pad_in = 4'h0;
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R1 oe", 32'(pad_oe), 32'h2);
        check("R1 out", 32'(pad_out), 32'h0);
        check("R1 strobe idle", 32'(sample_strobe), 32'h0);
        int_sample = 1'b1; #1;
        check("R1 strobe follows", 32'(sample_strobe), 32'h1);
        int_sample = 1'b0; #1;
    endtask

    task automatic t_ready_pulse();
        func_ctrl = 16'h000D; idle();
        int_sample = 1'b1; step(); int_sample = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R3 active high", 32'(pad_out[1]), 32'h1);
            step();
        end
        check("R3 pulse end", 32'(pad_out[1]), 32'h0);
        func_ctrl = 16'h0009; #1;
        check("R3 neg idle", 32'(pad_out[1]), 32'h1);
        int_sample = 1'b1; step(); int_sample = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R3 active low", 32'(pad_out[1]), 32'h0);
            step();
        end
        check("R3 neg end", 32'(pad_out[1]), 32'h1);
    endtask

    task automatic t_line_select();
        idle();
        for (int s = 0; s < 4; s++) begin
            func_ctrl = 16'h000C | 16'(s); #1;
            check("R2 drdy line", 32'(pad_oe), 32'(4'b0001 << s));
            check("R2 drdy idle", 32'(pad_out), 32'h0);
        end
        alarm_flag = 1'b1;
        for (int s = 0; s < 4; s++) begin
            func_ctrl = 16'h0C00 | 16'(s << 8); #1;
            check("R2 alarm line", 32'(pad_oe), 32'(4'b0001 << s));
        end
        alarm_flag = 1'b0;
    endtask

    task automatic t_alarm();
        func_ctrl = 16'h0E00; alarm_flag = 1'b0; #1;
        check("R4 oe", 32'(pad_oe), 32'h4);
        check("R4 pos low", 32'(pad_out[2]), 32'h0);
        alarm_flag = 1'b1; #1;
        check("R4 pos high", 32'(pad_out[2]), 32'h1);
        func_ctrl = 16'h0A00; #1;
        check("R4 neg set", 32'(pad_out[2]), 32'h0);
        alarm_flag = 1'b0; #1;
        check("R4 neg clear", 32'(pad_out[2]), 32'h1);
    endtask

    task automatic t_sync();
        func_ctrl = 16'h00F0; gpio_ctrl = 16'h0000; pad_in = 4'h0;
        idle();
        check("R6 sync oe", 32'(pad_oe), 32'h0);
        int_sample = 1'b1; #1;
        check("R5 internal ignored", 32'(sample_strobe), 32'h0);
        int_sample = 1'b0;
        pad_in[3] = 1'b1;
        step();
        check("R5 no early strobe", 32'(sample_strobe), 32'h0);
        step();
        check("R5 rising strobe", 32'(sample_strobe), 32'h1);
        step();
        check("R5 strobe one cycle", 32'(sample_strobe), 32'h0);
        pad_in[3] = 1'b0;
        step(); step();
        check("R5 falling ignored", 32'(sample_strobe), 32'h0);
        step();
        func_ctrl = 16'h00B0;
        pad_in[3] = 1'b1;
        step(); step();
        check("R5 rising ignored", 32'(sample_strobe), 32'h0);
        step();
        pad_in[3] = 1'b0;
        step(); step();
        check("R5 falling strobe", 32'(sample_strobe), 32'h1);
        pad_in = 4'h0;
    endtask

    task automatic t_gpio();
        func_ctrl = 16'h0000; gpio_ctrl = 16'h0015; pad_in = 4'b1010;
        step(); step(); #1;
        check("R7 oe", 32'(pad_oe), 32'h5);
        check("R7 out", 32'(pad_out), 32'h1);
        check("R8 readback", 32'(gpio_levels), 32'hB);
        pad_in = 4'b0000;
        step();
        check("R8 one stage", 32'(gpio_levels), 32'hB);
        step();
        check("R8 two stages", 32'(gpio_levels), 32'h1);
    endtask

    task automatic t_priority();
        gpio_ctrl = 16'h0000; func_ctrl = 16'h0CCC; alarm_flag = 1'b1;
        idle();
        check("R9 drdy wins oe", 32'(pad_oe), 32'h1);
        check("R9 drdy wins out", 32'(pad_out), 32'h0);
        int_sample = 1'b1; #1;
        check("R9 lost sync keeps int", 32'(sample_strobe), 32'h1);
        int_sample = 1'b0;
        func_ctrl = 16'h0DD0; #1;
        check("R9 alarm over sync oe", 32'(pad_oe), 32'h2);
        check("R9 alarm over sync out", 32'(pad_out), 32'h2);
        int_sample = 1'b1; #1;
        check("R9 int strobe", 32'(sample_strobe), 32'h1);
        int_sample = 1'b0; alarm_flag = 1'b0;
    endtask

    task automatic t_disabled();
        idle();
        func_ctrl = 16'h0337; gpio_ctrl = 16'h0088; #1;
        check("R10 oe", 32'(pad_oe), 32'h8);
        check("R10 out", 32'(pad_out), 32'h8);
        int_sample = 1'b1; #1;
        check("R10 int strobe", 32'(sample_strobe), 32'h1);
        int_sample = 1'b0;
    endtask

    task automatic t_reserved();
        idle();
        func_ctrl = 16'hF00D; gpio_ctrl = 16'h0000; #1;
        check("R11 func high bits", 32'(pad_oe), 32'h2);
        check("R11 func high out", 32'(pad_out), 32'h0);
        func_ctrl = 16'h0000; gpio_ctrl = 16'hFF00; #1;
        check("R11 gpio high bits", 32'(pad_oe), 32'h0);
        check("R11 gpio high out", 32'(pad_out), 32'h0);
    endtask

    initial begin
        t_reset();
        t_ready_pulse();
        t_line_select();
        t_alarm();
        t_sync();
        t_gpio();
        t_priority();
        t_disabled();
        t_reserved();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule